// File: doc/BRIEF.md
# Eight-Bit Add/Subtract Unit with Flags

The unit is a purely combinational adder/subtractor for a small datapath. Two operands enter together with a mode select and an external carry-in. In add mode the unit returns the operands' sum plus the carry-in. In subtract mode it inverts the second operand and forces the carry-in to one, so it returns the two's-complement difference. Alongside the result it returns an unsigned carry flag and a signed overflow flag.

The sum comes from two four-bit carry-lookahead groups. The carry out of the low group is the carry-in of the high group. Overflow is taken from the carries into and out of the most significant bit.

An output-enable decides whether the result is released to the surrounding datapath. While the enable is low, the result lines are held at zero and a valid strobe stays low. The flags stay live in both cases.

Top module: `addsub_unit`

## Requirements
- R1: With sub_i=0, result_o equals (a_i + b_i + cin_i) modulo 256.
- R2: With sub_i=0, carry_o equals bit 8 of the nine-bit sum a_i + b_i + cin_i.
- R3: With sub_i=1, result_o equals (a_i - b_i) modulo 256, and cin_i has no effect on result_o, carry_o or ovf_o.
- R4: With sub_i=1, carry_o is 1 exactly when a_i >= b_i as unsigned values, meaning no borrow occurred.
- R5: ovf_o is 1 exactly when the signed (two's-complement) result of the selected operation does not fit in 8 bits.
- R6: A carry produced in bits 3..0 reaches bits 7..4: for example 0f + 01 gives 10, and 0f + 00 with cin_i=1 gives 10.
- R7: With oe_i=1, valid_o is 1 and result_o carries the result. With oe_i=0, valid_o is 0 and result_o is 00, while carry_o and ovf_o still follow the operands.
- R8: Fixed vectors hold. Adding: f8+88=80 with C=1 and V=0; 55+55=aa with C=0 and V=1; 80+ff=7f with C=1 and V=1; 7f+01=80 with C=0 and V=1. Subtracting: 00-33=cd with C=0; 6c-00=6c with C=1; 80-01=7f with V=1; ec-70=7c with C=1 and V=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | 8 | First operand |
| b_i | input | 8 | Second operand |
| cin_i | input | 1 | Carry-in, used in add mode only |
| sub_i | input | 1 | 1 selects a_i - b_i, 0 selects addition |
| oe_i | input | 1 | Output enable for result_o |
| result_o | output | 8 | Gated result |
| valid_o | output | 1 | High while result_o is released |
| carry_o | output | 1 | Carry out; in subtract mode, the inverse of borrow |
| ovf_o | output | 1 | Signed overflow |

## Verification
Two functions can meet in one evaluation. The first is output gating while the flags stay live. The second is a carry crossing between the lookahead groups at the same moment the signed overflow is decided. The bench drops oe_i while feeding operands that overflow and carry across the group boundary. It then judges that result_o is zero and valid_o is low, while carry_o and ovf_o still match values it computes from a wide integer sum. The exhaustive sweeps over both modes and both carry-in values catch every case where an inter-group carry and an overflow occur together.

// File: rtl/addsub_pkg.sv
package addsub_pkg;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned GRP_W  = 4;
  localparam int unsigned N_GRP  = DATA_W / GRP_W;

  typedef logic [DATA_W-1:0] word_t;
endpackage

// File: rtl/cla_group.sv
module cla_group #(
  parameter int unsigned W = 4
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         c_i,
  output logic [W-1:0] s_o,
  output logic [W:0]   c_o   // c_o[k] = carry into bit k, c_o[W] = group carry out
);
  logic [W-1:0] g, p;

  assign g = a_i & b_i;
  assign p = a_i ^ b_i;

  // lookahead: each carry expanded from generate/propagate terms, no chaining
  always_comb begin
    c_o[0] = c_i;
    for (int k = 1; k <= W; k++) begin
      logic term;
      logic acc;
      acc  = 1'b0;
      for (int j = 0; j < k; j++) begin
        term = g[j];
        for (int m = j + 1; m < k; m++) term = term & p[m];
        acc = acc | term;
      end
      term = c_i;
      for (int m = 0; m < k; m++) term = term & p[m];
      c_o[k] = acc | term;
    end
  end

  assign s_o = p ^ c_o[W-1:0];
endmodule

// File: rtl/addsub_core.sv
module addsub_core
  import addsub_pkg::*;
#(
  parameter int unsigned DW = DATA_W,
  parameter int unsigned GW = GRP_W
) (
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  input  logic          c_i,
  output logic [DW-1:0] s_o,
  output logic          co_o,
  output logic          ovf_o
);
  localparam int unsigned NG = DW / GW;

  logic [NG:0]   grp_c;
  logic [DW:0]   bit_c;

  assign grp_c[0] = c_i;

  for (genvar gi = 0; gi < NG; gi++) begin : g_grp
    logic [GW:0] cc;
    cla_group #(.W(GW)) u_grp (
      .a_i (a_i[gi*GW +: GW]),
      .b_i (b_i[gi*GW +: GW]),
      .c_i (grp_c[gi]),
      .s_o (s_o[gi*GW +: GW]),
      .c_o (cc)
    );
    assign grp_c[gi+1]          = cc[GW];
    assign bit_c[gi*GW +: GW]   = cc[GW-1:0];
  end

  assign bit_c[DW] = grp_c[NG];
  assign co_o      = bit_c[DW];
  assign ovf_o     = bit_c[DW] ^ bit_c[DW-1];
endmodule

// File: rtl/out_gate.sv
module out_gate #(
  parameter int unsigned DW = 8
) (
  input  logic [DW-1:0] d_i,
  input  logic          en_i,
  output logic [DW-1:0] q_o,
  output logic          vld_o
);
  assign q_o   = en_i ? d_i : '0;
  assign vld_o = en_i;
endmodule

// File: rtl/addsub_unit.sv
module addsub_unit
  import addsub_pkg::*;
(
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic              cin_i,
  input  logic              sub_i,
  input  logic              oe_i,
  output logic [DATA_W-1:0] result_o,
  output logic              valid_o,
  output logic              carry_o,
  output logic              ovf_o
);
  word_t b_eff, sum;
  logic  c_eff;

  // subtract = a + ~b + 1; external carry-in ignored in that mode
  assign b_eff = sub_i ? ~b_i : b_i;
  assign c_eff = sub_i | cin_i;

  addsub_core #(.DW(DATA_W), .GW(GRP_W)) u_core (
    .a_i   (a_i),
    .b_i   (b_eff),
    .c_i   (c_eff),
    .s_o   (sum),
    .co_o  (carry_o),
    .ovf_o (ovf_o)
  );

  out_gate #(.DW(DATA_W)) u_gate (
    .d_i   (sum),
    .en_i  (oe_i),
    .q_o   (result_o),
    .vld_o (valid_o)
  );
endmodule

// File: rtl/addsub_unit_chk.sv
module addsub_unit_chk
  import addsub_pkg::*;
(
  input logic [DATA_W-1:0] a_i,
  input logic [DATA_W-1:0] b_i,
  input logic              cin_i,
  input logic              sub_i,
  input logic              oe_i,
  input logic [DATA_W-1:0] result_o,
  input logic              valid_o,
  input logic              carry_o,
  input logic              ovf_o
);
  logic [DATA_W:0] ref_add, ref_sub;
  logic            sa, sb, sr;

  always_comb begin
    ref_add = {1'b0, a_i} + {1'b0, b_i} + {{DATA_W{1'b0}}, cin_i};
    ref_sub = {1'b0, a_i} - {1'b0, b_i};
    sa = a_i[DATA_W-1];
    sb = b_i[DATA_W-1] ^ sub_i;
    sr = sub_i ? ref_sub[DATA_W-1] : ref_add[DATA_W-1];

    if (oe_i && !sub_i)
      assert_add_sum_R1: assert (result_o == ref_add[DATA_W-1:0]);
    if (!sub_i)
      assert_add_carry_R2: assert (carry_o == ref_add[DATA_W]);
    if (oe_i && sub_i)
      assert_sub_diff_R3: assert (result_o == ref_sub[DATA_W-1:0]);
    if (sub_i)
      assert_no_borrow_R4: assert (carry_o == (a_i >= b_i));
    assert_ovf_R5: assert (ovf_o == ((sa == sb) && (sr != sa)));
    if (!oe_i)
      assert_gated_R7: assert (result_o == '0 && !valid_o);
    else
      assert_released_R7: assert (valid_o);
  end
endmodule

bind addsub_unit addsub_unit_chk u_chk (.*);

// File: tb/addsub_unit_test.sv
`timescale 1ns/1ps
module addsub_unit_test;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [7:0] a, b, res;
  logic       cin, sub, oe, vld, co, ov;
  int         n_chk = 0, n_fail = 0;
  bit         done = 1'b0;

  always #2 clk = ~clk;

  addsub_unit uut (
    .a_i(a), .b_i(b), .cin_i(cin), .sub_i(sub), .oe_i(oe),
    .result_o(res), .valid_o(vld), .carry_o(co), .ovf_o(ov)
  );

  task automatic apply(input logic [7:0] ta, tb_, input logic tc, ts, to);
    a = ta; b = tb_; cin = tc; sub = ts; oe = to;
    #1;
  endtask

  task automatic chk(input string req, input logic [15:0] act, exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s a=%h b=%h sub=%0b cin=%0b oe=%0b act=%h exp=%h",
               req, a, b, sub, cin, oe, act, exp);
    end
  endtask

  function automatic logic ovf_ref(input logic [7:0] x, y, r, input logic s);
    logic ys;
    ys = y[7] ^ s;
    return (x[7] == ys) && (r[7] != x[7]);
  endfunction

  task automatic t_reset_state();
    apply(8'h00, 8'h00, 1'b0, 1'b0, 1'b0);
    chk("R7 idle result", {8'h0, res}, 16'h0);
    chk("R7 idle valid", {15'h0, vld}, 16'h0);
  endtask

  task automatic t_sweep_add();
    for (int c = 0; c < 2; c++)
      for (int i = 0; i < 256; i++)
        for (int j = 0; j < 256; j++) begin
          logic [8:0] s;
          s = 9'(i) + 9'(j) + 9'(c);
          apply(8'(i), 8'(j), c[0], 1'b0, 1'b1);
          chk("R1", {8'h0, res}, {8'h0, s[7:0]});
          chk("R2", {15'h0, co}, {15'h0, s[8]});
          chk("R5 add", {15'h0, ov}, {15'h0, ovf_ref(8'(i), 8'(j), s[7:0], 1'b0)});
        end
  endtask

  task automatic t_sweep_sub();
    for (int c = 0; c < 2; c++)
      for (int i = 0; i < 256; i++)
        for (int j = 0; j < 256; j++) begin
          logic [7:0] d;
          d = 8'(i - j);
          apply(8'(i), 8'(j), c[0], 1'b1, 1'b1);
          chk("R3", {8'h0, res}, {8'h0, d});
          chk("R4", {15'h0, co}, {15'h0, logic'(i >= j)});
          chk("R5 sub", {15'h0, ov}, {15'h0, ovf_ref(8'(i), 8'(j), d, 1'b1)});
        end
  endtask

  task automatic t_group_carry();
    apply(8'h0f, 8'h01, 1'b0, 1'b0, 1'b1); chk("R6 0f+01", {8'h0, res}, 16'h10);
    apply(8'h0f, 8'h00, 1'b1, 1'b0, 1'b1); chk("R6 0f+cin", {8'h0, res}, 16'h10);
    apply(8'hff, 8'h00, 1'b1, 1'b0, 1'b1); chk("R6 ff+cin", {7'h0, co, res}, 16'h100);
  endtask

  task automatic t_gating_overlap();
    // gated while overflow and group carry both active
    apply(8'h7f, 8'h01, 1'b0, 1'b0, 1'b0);
    chk("R7 gated result", {8'h0, res}, 16'h0);
    chk("R7 gated valid", {15'h0, vld}, 16'h0);
    chk("R7 gated flags", {14'h0, co, ov}, 16'h1);
    apply(8'h80, 8'hff, 1'b0, 1'b0, 1'b0);
    chk("R7 gated flags2", {14'h0, co, ov}, 16'h3);
    apply(8'h80, 8'hff, 1'b0, 1'b0, 1'b1);
    chk("R7 released", {7'h0, vld, res}, 16'h17f);
  endtask

  task automatic vec(input logic s, input logic [7:0] x, y, r, input logic ec, ev, input bit chk_c);
    apply(x, y, 1'b0, s, 1'b1);
    chk("R8 result", {8'h0, res}, {8'h0, r});
    if (chk_c) chk("R8 carry", {15'h0, co}, {15'h0, ec});
    chk("R8 ovf", {15'h0, ov}, {15'h0, ev});
  endtask

  task automatic t_vectors();
    vec(1'b0, 8'hf8, 8'h88, 8'h80, 1'b1, 1'b0, 1'b1);
    vec(1'b0, 8'h55, 8'h55, 8'haa, 1'b0, 1'b1, 1'b1);
    vec(1'b0, 8'h80, 8'hff, 8'h7f, 1'b1, 1'b1, 1'b1);
    vec(1'b0, 8'h7f, 8'h01, 8'h80, 1'b0, 1'b1, 1'b1);
    vec(1'b1, 8'h00, 8'h33, 8'hcd, 1'b0, 1'b0, 1'b1);
    vec(1'b1, 8'h6c, 8'h00, 8'h6c, 1'b1, 1'b0, 1'b1);
    vec(1'b1, 8'h80, 8'h01, 8'h7f, 1'b1, 1'b1, 1'b0);
    vec(1'b1, 8'hec, 8'h70, 8'h7c, 1'b1, 1'b1, 1'b1);
    // R3: carry-in ignored in subtract mode
    apply(8'h10, 8'h01, 1'b1, 1'b1, 1'b1);
    chk("R3 cin ignored", {6'h0, co, ov, res}, {6'h0, 1'b1, 1'b0, 8'h0f});
  endtask

  initial begin : watchdog
    #700000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog act=timeout exp=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    apply(8'h00, 8'h00, 1'b0, 1'b0, 1'b0);
    repeat (3) @(posedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset_state();
    t_group_carry();
    t_gating_overlap();
    t_vectors();
    t_sweep_add();
    t_sweep_sub();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule